// File: doc/BRIEF.md
# Alternating-Half Sample Capture Buffer

The block takes a continuous stream of 16-bit samples and writes them, one per accepted beat, into a storage array split into a lower and an upper half. The write pointer runs through the lower half, then straight on through the upper half, then wraps back to the bottom. Incoming data never waits. Each time the pointer finishes a half, the block pulses that half's own active-low interrupt line, so a host knows which region is now complete.

The host drains a completed half through a simple asynchronous-style read port. The port has a 10-bit address, chip select, output enable and a per-beat strobe. When chip select falls, the read pointer loads the address. Each later falling edge of the strobe steps the pointer forward by one word. A burst therefore walks through a half without a new address for every beat.

The block remembers which halves hold data the host has not yet finished reading. If the writer completes a half while the other half is still waiting to be drained, a sticky overrun flag is raised. The writer keeps capturing new data anyway.

Top module: `ppbuf_capture`

## Requirements
- R1: After reset, both interrupt lines are high, the overrun flag is low, the data-drive enable is low and the read data output is zero.
- R2: Each cycle with `wr_valid_i` high stores `wr_data_i` at the write pointer and then advances the pointer by one, wrapping from the top word to word 0. Cycles with `wr_valid_i` low store nothing and leave the pointer unchanged.
- R3: A write to the last word of the lower half (address 2^(ADDR_W-1)-1) drives `irq_n_o[0]` low from the next clock edge. A write to the last word of the upper half (address 2^ADDR_W-1) does the same for `irq_n_o[1]`. The line stays low for exactly IRQ_CYCLES cycles (default 4) and then returns high. The other line is not affected, and neither line goes low before its half is complete.
- R4: On the first clock edge at which `host_cs_n_i` is sampled low after being high, the read pointer loads `host_addr_i`. The word stored at that address appears on `rdata_o` right after that same edge.
- R5: While chip select is low, a strobe sampled high on one edge and low on the next advances the read pointer by one, wrapping from the top word to word 0. The next word appears on `rdata_o` right after the edge that detects the fall.
- R6: `rdata_oe_o` is high only while both `host_cs_n_i` and `host_oe_n_i` are low. Whenever it is low, `rdata_o` is forced to zero so the pad can be released.
- R7: A half becomes unread when its last word is written. It becomes read again when the read pointer moves onto the last word of that half, either by an address load or by a strobe step.
- R8: When the writer completes one half while the other half is still unread, `overrun_o` goes high on the next edge and stays high until reset. Writing carries on into that half regardless.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Sample-valid for the capture stream |
| wr_data_i | input | DATA_W | Sample value |
| host_cs_n_i | input | 1 | Host chip select, active low |
| host_oe_n_i | input | 1 | Host output enable, active low |
| host_addr_i | input | ADDR_W | Burst start address, loaded when chip select falls |
| host_strobe_i | input | 1 | Per-beat strobe; a falling edge advances the read pointer |
| rdata_o | output | DATA_W | Read data (zero while not driven) |
| rdata_oe_o | output | 1 | Data pad drive enable |
| irq_n_o | output | 2 | Per-half completion interrupt, active low; bit 0 lower half, bit 1 upper half |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
Several properties are checked on every cycle. These are: the write pointer holds or steps according to the valid input, each interrupt falls right after its half completes, no interrupt stays low longer than its pulse length, the overrun flag never clears, and the data output is quiet whenever it is not driven. Other behaviour can only be shown by the bench's scenarios, because it depends on the captured data itself. This covers the actual data returned by address loads and strobe-stepped bursts, including the wrap past the top word. It also covers the read-marking of a half after its last word is fetched, and the difference between a drained half, which gives no overrun, and an undrained one, which does.

// File: rtl/ppbuf_pkg.sv
package ppbuf_pkg;

    localparam int NUM_HALVES = 2;

    // Address of the final word in half h of a 2**addr_w array.
    function automatic int half_last_word(int addr_w, int h);
        return ((h + 1) << (addr_w - 1)) - 1;
    endfunction

endpackage

// File: rtl/ppbuf_store.sv
module ppbuf_store #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_data_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
        rd_data_q <= mem_q[rd_addr];
    end

    assign rd_data = rd_data_q;

endmodule

// File: rtl/ppbuf_wr_ctrl.sv
module ppbuf_wr_ctrl
    import ppbuf_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid_i,
    input  logic [NUM_HALVES-1:0] rd_done_i,
    output logic [ADDR_W-1:0]     wr_ptr_o,
    output logic [NUM_HALVES-1:0] half_done_o,
    output logic                  overrun_o
);
    typedef struct packed {
        logic [ADDR_W-1:0]     ptr;
        logic [NUM_HALVES-1:0] unread;
        logic                  overrun;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic [NUM_HALVES-1:0] done;

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half_end
        localparam logic [ADDR_W-1:0] LASTW = ADDR_W'(half_last_word(ADDR_W, h));
        assign done[h] = wr_valid_i && (st_q.ptr == LASTW);
    end

    always_comb begin
        st_d = st_q;
        if (wr_valid_i) begin
            st_d.ptr = st_q.ptr + ADDR_W'(1);
        end
        // completion wins over a same-cycle read-out of the same half
        st_d.unread = (st_q.unread & ~rd_done_i) | done;
        // finishing half h means the writer enters the other half
        if ((done[0] && st_q.unread[1]) || (done[1] && st_q.unread[0])) begin
            st_d.overrun = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr_o    = st_q.ptr;
    assign half_done_o = done;
    assign overrun_o   = st_q.overrun;

endmodule

// File: rtl/ppbuf_rd_port.sv
module ppbuf_rd_port
    import ppbuf_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n_i,
    input  logic                  strobe_i,
    input  logic [ADDR_W-1:0]     addr_i,
    output logic [ADDR_W-1:0]     rd_addr_o,
    output logic [NUM_HALVES-1:0] rd_done_o
);
    typedef struct packed {
        logic              cs_n_prev;
        logic              stb_prev;
        logic [ADDR_W-1:0] ptr;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      start, step, move;

    always_comb begin
        st_d           = st_q;
        start          = st_q.cs_n_prev && !cs_n_i;
        step           = !cs_n_i && !start && st_q.stb_prev && !strobe_i;
        move           = start || step;
        st_d.cs_n_prev = cs_n_i;
        st_d.stb_prev  = strobe_i;
        if (start) begin
            st_d.ptr = addr_i;
        end else if (step) begin
            st_d.ptr = st_q.ptr + ADDR_W'(1);
        end
    end

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_drain
        localparam logic [ADDR_W-1:0] LASTW = ADDR_W'(half_last_word(ADDR_W, h));
        assign rd_done_o[h] = move && (st_d.ptr == LASTW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cs_n_prev: 1'b1, stb_prev: 1'b0, ptr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // storage is read with the next pointer so data tracks the pointer register
    assign rd_addr_o = st_d.ptr;

endmodule

// File: rtl/ppbuf_irq_pulse.sv
module ppbuf_irq_pulse #(
    parameter int IRQ_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic irq_n_o
);
    localparam int CNT_W = $clog2(IRQ_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (trig_i) begin
            cnt_d = CNT_W'(IRQ_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign irq_n_o = (cnt_q == '0);

endmodule

// File: rtl/ppbuf_capture.sv
module ppbuf_capture
    import ppbuf_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 10,
    parameter int IRQ_CYCLES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    input  logic                  host_cs_n_i,
    input  logic                  host_oe_n_i,
    input  logic [ADDR_W-1:0]     host_addr_i,
    input  logic                  host_strobe_i,
    output logic [DATA_W-1:0]     rdata_o,
    output logic                  rdata_oe_o,
    output logic [NUM_HALVES-1:0] irq_n_o,
    output logic                  overrun_o
);
    logic [ADDR_W-1:0]     wr_ptr;
    logic [ADDR_W-1:0]     rd_addr;
    logic [NUM_HALVES-1:0] half_done;
    logic [NUM_HALVES-1:0] rd_done;
    logic [DATA_W-1:0]     rd_word;

    ppbuf_wr_ctrl #(.ADDR_W(ADDR_W)) i_wr_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid_i  (wr_valid_i),
        .rd_done_i   (rd_done),
        .wr_ptr_o    (wr_ptr),
        .half_done_o (half_done),
        .overrun_o   (overrun_o)
    );

    ppbuf_rd_port #(.ADDR_W(ADDR_W)) i_rd_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_i    (host_cs_n_i),
        .strobe_i  (host_strobe_i),
        .addr_i    (host_addr_i),
        .rd_addr_o (rd_addr),
        .rd_done_o (rd_done)
    );

    ppbuf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_store (
        .clk     (clk),
        .wr_en   (wr_valid_i),
        .wr_addr (wr_ptr),
        .wr_data (wr_data_i),
        .rd_addr (rd_addr),
        .rd_data (rd_word)
    );

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_irq
        ppbuf_irq_pulse #(.IRQ_CYCLES(IRQ_CYCLES)) i_irq (
            .clk     (clk),
            .rst_n   (rst_n),
            .trig_i  (half_done[h]),
            .irq_n_o (irq_n_o[h])
        );
    end

    assign rdata_oe_o = !host_cs_n_i && !host_oe_n_i;
    assign rdata_o    = rdata_oe_o ? rd_word : '0;

endmodule

// File: rtl/ppbuf_capture_chk.sv
module ppbuf_capture_chk
    import ppbuf_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 10,
    parameter int IRQ_CYCLES = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_valid_i,
    input logic [ADDR_W-1:0]     wr_ptr,
    input logic                  host_cs_n_i,
    input logic [DATA_W-1:0]     rdata_o,
    input logic                  rdata_oe_o,
    input logic [NUM_HALVES-1:0] irq_n_o,
    input logic                  overrun_o
);
    a_r2_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid_i |=> $stable(wr_ptr));

    a_r2_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_i |=> (wr_ptr == $past(wr_ptr) + ADDR_W'(1)));

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        localparam logic [ADDR_W-1:0] LASTW = ADDR_W'(half_last_word(ADDR_W, h));
        int low_cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                low_cnt <= 0;
            end else if (!irq_n_o[h]) begin
                low_cnt <= low_cnt + 1;
            end else begin
                low_cnt <= 0;
            end
        end

        a_r3_irq_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_valid_i && wr_ptr == LASTW) |=> !irq_n_o[h]);

        a_r3_irq_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
            low_cnt <= IRQ_CYCLES);
    end

    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    a_r6_idle_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        host_cs_n_i |-> !rdata_oe_o);

    a_r6_quiet_when_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe_o |-> (rdata_o == '0));

endmodule

bind ppbuf_capture ppbuf_capture_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IRQ_CYCLES(IRQ_CYCLES)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid_i  (wr_valid_i),
    .wr_ptr      (wr_ptr),
    .host_cs_n_i (host_cs_n_i),
    .rdata_o     (rdata_o),
    .rdata_oe_o  (rdata_oe_o),
    .irq_n_o     (irq_n_o),
    .overrun_o   (overrun_o)
);

// File: tb/test_ppbuf_capture.sv
module test_ppbuf_capture;
    localparam int DW    = 16;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = DEPTH / 2;
    localparam int IRQC  = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic          rst_n;
    logic          wr_valid;
    logic [DW-1:0] wr_data;
    logic          cs_n, oe_n, stb;
    logic [AW-1:0] addr;
    logic [DW-1:0] rdata;
    logic          rdata_oe;
    logic [1:0]    irq_n;
    logic          overrun;

    ppbuf_capture #(.DATA_W(DW), .ADDR_W(AW), .IRQ_CYCLES(IRQC)) i_ppbuf_capture (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_valid_i    (wr_valid),
        .wr_data_i     (wr_data),
        .host_cs_n_i   (cs_n),
        .host_oe_n_i   (oe_n),
        .host_addr_i   (addr),
        .host_strobe_i (stb),
        .rdata_o       (rdata),
        .rdata_oe_o    (rdata_oe),
        .irq_n_o       (irq_n),
        .overrun_o     (overrun)
    );

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] model [DEPTH];
    int wptr   = 0;
    int wcount = 0;

    logic [DW-1:0] exp_q [$];
    string         req_q [$];
    bit            pending = 1'b0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] sample_val(int k);
        return DW'(k * 953 + 90) ^ 16'hC3A5;
    endfunction

    // monitor: compares each read beat against the scoreboard
    always begin
        @(posedge clk);
        #2;
        if (pending) begin
            logic [DW-1:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(rdata == e, r, "read beat data", rdata, e);
            check(rdata_oe == 1'b1, "R6", "drive enable during read", rdata_oe, 1);
            pending = 1'b0;
        end
    end

    task automatic write_words(int n, bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 5 == 2)) begin
                wr_valid = 1'b0;
                wr_data  = 16'hDEAD;   // must not be stored (R2)
                @(negedge clk);
            end
            wr_valid    = 1'b1;
            wr_data     = sample_val(wcount);
            model[wptr] = sample_val(wcount);
            wptr        = (wptr + 1) % DEPTH;
            wcount++;
            @(negedge clk);
        end
        wr_valid = 1'b0;
    endtask

    task automatic read_burst(int start, int n);
        addr = AW'(start);
        cs_n = 1'b0;
        oe_n = 1'b0;
        exp_q.push_back(model[start]);
        req_q.push_back("R4");
        pending = 1'b1;
        @(negedge clk);
        for (int i = 1; i < n; i++) begin
            stb = 1'b1;
            @(negedge clk);
            stb = 1'b0;
            exp_q.push_back(model[(start + i) % DEPTH]);
            req_q.push_back("R5");
            pending = 1'b1;
            @(negedge clk);
        end
        cs_n = 1'b1;
        oe_n = 1'b1;
        @(negedge clk);
    endtask

    // called at the negedge right after the completing write edge
    task automatic check_irq(int h);
        check(irq_n[1-h] == 1'b1, "R3", "other line untouched", irq_n[1-h], 1);
        for (int k = 0; k < IRQC; k++) begin
            check(irq_n[h] == 1'b0, "R3", "line low during pulse", irq_n[h], 0);
            @(negedge clk);
        end
        check(irq_n[h] == 1'b1, "R3", "line released after pulse", irq_n[h], 1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n    = 1'b0;
        wr_valid = 1'b0;
        wr_data  = '0;
        cs_n     = 1'b1;
        oe_n     = 1'b1;
        stb      = 1'b0;
        addr     = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(irq_n == 2'b11, "R1", "interrupts idle", irq_n, 2'b11);
        check(overrun == 1'b0, "R1", "overrun clear", overrun, 0);
        check(rdata_oe == 1'b0, "R1", "no drive", rdata_oe, 0);
        check(rdata == '0, "R1", "data zero", rdata, 0);

        // R2/R3: fill lower half except its last word, with idle gaps
        write_words(HALF - 1, 1'b1);
        check(irq_n == 2'b11, "R3", "no early interrupt", irq_n, 2'b11);
        write_words(1, 1'b0);
        check_irq(0);

        // R6: selected but output enable high
        cs_n = 1'b0;
        oe_n = 1'b1;
        @(negedge clk);
        check(rdata_oe == 1'b0, "R6", "enable low with oe_n high", rdata_oe, 0);
        check(rdata == '0, "R6", "data zero with oe_n high", rdata, 0);
        cs_n = 1'b1;
        @(negedge clk);

        // R2/R4/R5: burst through stored lower-half data (gaps skipped)
        read_burst(0, 16);
        read_burst(100, 3);

        // R7: fetch last word of the lower half -> marked read
        read_burst(HALF - 1, 1);

        // upper half completes; lower is drained so no overrun (R7)
        write_words(HALF, 1'b1);
        check_irq(1);
        check(overrun == 1'b0, "R7", "drained half gives no overrun", overrun, 0);

        // lower half completes again while upper unread -> overrun (R8)
        write_words(HALF, 1'b0);
        check_irq(0);
        check(overrun == 1'b1, "R8", "overrun on undrained half", overrun, 1);

        // R8: writing continues into the unread half
        write_words(20, 1'b1);
        read_burst(HALF, 20);
        check(overrun == 1'b1, "R8", "overrun sticky", overrun, 1);

        // R5: read pointer wraps from top word to word 0
        read_burst(DEPTH - 2, 3);
        check(overrun == 1'b1, "R8", "overrun still sticky", overrun, 1);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule